// File: doc/BRIEF.md
# Windowed Register Call Controller

This block keeps the call-window state of a register file built from NAREG physical registers taken four at a time. It holds the current window position (the base, counted in quads) and a live-frame mask with one bit per quad. The register storage is not part of the block. A pipeline presents one window operation per cycle: a call-frame entry, a windowed return, a window rotate, a stack-move check, a direct base write, or a restore of the saved base.

For each operation the block drives these results in the same cycle:
- any register write, as a window-relative index and a value;
- any return address;
- any exception request, with its kind;
- any update of the saved-base field, the exception-mode bit and the exception PC.

The new base and mask take effect at the next clock edge.

On a call, the block finds the nearest live frame above the current base by rotating the mask. If a live frame lies inside the requested call increment, the block spills by raising an overflow, and the size of that overflow (4, 8 or 12 registers) follows from the gap to the frame after it. On a return, a missing caller frame raises an underflow sized by the return increment.

Top module: `win_call_ctrl`

## Requirements
- R1: After reset the base is 0, the mask has only bit 0 set, and with opcode 0 (no-op) every output request is inactive and exc_kind is 0.
- R2: Opcode 3 adds the signed 4-bit rot_amt to the base. All base arithmetic wraps modulo NAREG/4.
- R3: Opcode 1 (entry) with s_idx above 3, or with ps_woe=0, or with ps_excm=1, gives exc_kind 1 (illegal). It writes no register and leaves the base and mask unchanged.
- R4: A legal entry whose low ps_callinc bits of the mask, rotated right by base+1, contain a set bit is an overflow. The base advances by n, where n is the number of trailing zeros of the rotated mask plus 1. The saved-base output carries the old base, and excm_set and epc_we (with pc_val) are asserted. No register is written.
- R5: The overflow kind is taken from the trailing-zero count of the rotated mask shifted right by n: a count of 0 gives exc_kind 3, a count of 1 gives exc_kind 4, and any larger count gives exc_kind 5.
- R6: A legal entry with no overflow writes src_val − imm_val to window index {ps_callinc, s_idx[1:0]}. The base advances by ps_callinc, and the mask bit of the new base is set.
- R7: Opcode 2 (return) takes n from a0_val[31:30]. m is the smallest distance d in 1..3 for which the mask bit at base−d is set, or 0 if none of them is set. The return gives exc_kind 1 when n=0, when m≠0 and m≠n, or when ps_woe=0 or ps_excm=1, and in that case the state is unchanged.
- R8: A legal return whose new base (base−n) has its mask bit set clears the old base's bit and moves the base. It also asserts ret_valid with ret_pc = {pc_val[31:30], a0_val[29:0]}.
- R9: A legal return whose new base has its mask bit clear still moves the base, leaves the mask unchanged, and gives exc_kind 5+n (6, 7 or 8). The saved-base output carries the old base, with excm_set and epc_we asserted.
- R10: Opcode 4 (stack-move check) gives exc_kind 2 when none of the mask bits at base−1, base−2 and base−3 is set. It never changes the state.
- R11: Opcode 5 loads the base from base_wr, and opcode 6 loads it from ps_owb. Neither changes the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code (0 nop, 1 entry, 2 return, 3 rotate, 4 stack-move check, 5 base write, 6 saved-base restore) |
| s_idx | input | 4 | Source register index of an entry |
| src_val | input | 32 | Value of the entry source register |
| imm_val | input | 32 | Frame size subtracted by an entry |
| a0_val | input | 32 | Return-address register for a return |
| pc_val | input | 32 | PC of the current operation |
| rot_amt | input | 4 | Signed rotate amount |
| base_wr | input | QW | Base value for opcode 5 |
| ps_woe | input | 1 | Window-overflow enable |
| ps_excm | input | 1 | Exception mode |
| ps_callinc | input | 2 | Call increment |
| ps_owb | input | QW | Saved base |
| win_base | output | QW | Current base |
| win_start | output | NQ | Live-frame mask |
| rf_we | output | 1 | Register write request |
| rf_idx | output | 4 | Window-relative write index |
| rf_wdata | output | 32 | Write value |
| ret_valid | output | 1 | Return address valid |
| ret_pc | output | 32 | Return address |
| exc_valid | output | 1 | Exception request |
| exc_kind | output | 4 | Exception kind (1 illegal, 2 alloca, 3..5 overflow 4/8/12, 6..8 underflow 4/8/12) |
| owb_we | output | 1 | Saved-base update request |
| owb_wdata | output | QW | New saved base |
| excm_set | output | 1 | Set exception mode |
| epc_we | output | 1 | Exception PC write |
| epc_wdata | output | 32 | Exception PC value |

## Verification
Directed patterns cover the following cases:
- a wrapped base followed by a call whose increment reaches a live frame, which must be an overflow of the smallest size;
- a call with an out-of-range source index;
- a restore of the saved base.

Random sequences mix calls, returns, rotates and base writes with mostly legal mode bits. As a result the live-frame mask fills and drains in many shapes. This separates the three overflow sizes by the gap to the following frame, and tells an underflow from a normal return by whether the caller's bit survives. Random return-address top bits also produce both the mismatch and the zero-increment illegal returns.

// File: rtl/win_call_ctrl.sv
module win_call_ctrl #(
  parameter int NAREG = 64,
  localparam int NQ = NAREG / 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [3:0]    s_idx,
  input  logic [31:0]   src_val,
  input  logic [31:0]   imm_val,
  input  logic [31:0]   a0_val,
  input  logic [31:0]   pc_val,
  input  logic [3:0]    rot_amt,
  input  logic [QW-1:0] base_wr,
  input  logic          ps_woe,
  input  logic          ps_excm,
  input  logic [1:0]    ps_callinc,
  input  logic [QW-1:0] ps_owb,
  output logic [QW-1:0] win_base,
  output logic [NQ-1:0] win_start,
  output logic          rf_we,
  output logic [3:0]    rf_idx,
  output logic [31:0]   rf_wdata,
  output logic          ret_valid,
  output logic [31:0]   ret_pc,
  output logic          exc_valid,
  output logic [3:0]    exc_kind,
  output logic          owb_we,
  output logic [QW-1:0] owb_wdata,
  output logic          excm_set,
  output logic          epc_we,
  output logic [31:0]   epc_wdata
);
  localparam logic [2:0] OP_ENTRY = 3'd1, OP_RETW = 3'd2, OP_ROTW = 3'd3,
                         OP_MOVSP = 3'd4, OP_WBSET = 3'd5, OP_OWBRST = 3'd6;
  localparam logic [3:0] K_ILL = 4'd1, K_ALLOCA = 4'd2, K_OV4 = 4'd3,
                         K_OV8 = 4'd4, K_OV12 = 4'd5;

  logic [QW-1:0] wb_q, wb_d;
  logic [NQ-1:0] ws_q, ws_d;

  function automatic logic [NQ-1:0] rotr(input logic [NQ-1:0] v, input int amt);
    return (v >> amt) | (v << (NQ - amt));
  endfunction

  function automatic int tzc(input logic [NQ-1:0] v);
    int r;
    r = NQ;
    for (int i = NQ - 1; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [NQ-1:0] bit_at(input logic [QW-1:0] p);
    return NQ'(1) << p;
  endfunction

  logic [NQ-1:0] rot_ws, tail_ws;
  logic [NQ-1:0] call_mask;
  int            ov_n, ov_k;
  logic [1:0]    ret_n;
  logic [1:0]    ret_m;
  logic [QW-1:0] back1, back2, back3, ret_base;
  logic [QW+3:0] rot_ext;
  logic          mode_ok;

  assign mode_ok   = ps_woe && !ps_excm;
  assign rot_ws    = rotr(ws_q, int'(wb_q) + 1);
  assign call_mask = NQ'((1 << ps_callinc) - 1);
  assign ov_n      = tzc(rot_ws) + 1;
  assign tail_ws   = rot_ws >> ov_n;
  assign ov_k      = tzc(tail_ws);
  assign ret_n     = a0_val[31:30];
  assign back1     = wb_q - QW'(1);
  assign back2     = wb_q - QW'(2);
  assign back3     = wb_q - QW'(3);
  assign ret_m     = ws_q[back1] ? 2'd1 : ws_q[back2] ? 2'd2 : ws_q[back3] ? 2'd3 : 2'd0;
  assign ret_base  = wb_q - QW'(ret_n);
  assign rot_ext   = {{QW{rot_amt[3]}}, rot_amt};

  always_comb begin
    wb_d      = wb_q;
    ws_d      = ws_q;
    rf_we     = 1'b0;
    rf_idx    = 4'd0;
    rf_wdata  = 32'd0;
    ret_valid = 1'b0;
    ret_pc    = 32'd0;
    exc_kind  = 4'd0;
    owb_we    = 1'b0;
    owb_wdata = '0;
    excm_set  = 1'b0;
    epc_we    = 1'b0;
    epc_wdata = 32'd0;
    case (op)
      OP_ENTRY: begin
        if (s_idx > 4'd3 || !mode_ok) begin
          exc_kind = K_ILL;
        end else if ((rot_ws & call_mask) != '0) begin
          wb_d      = wb_q + QW'(ov_n);
          owb_we    = 1'b1;
          owb_wdata = wb_q;
          excm_set  = 1'b1;
          epc_we    = 1'b1;
          epc_wdata = pc_val;
          exc_kind  = (ov_k == 0) ? K_OV4 : (ov_k == 1) ? K_OV8 : K_OV12;
        end else begin
          rf_we    = 1'b1;
          rf_idx   = {ps_callinc, s_idx[1:0]};
          rf_wdata = src_val - imm_val;
          wb_d     = wb_q + QW'(ps_callinc);
          ws_d     = ws_q | bit_at(wb_q + QW'(ps_callinc));
        end
      end
      OP_RETW: begin
        if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !mode_ok) begin
          exc_kind = K_ILL;
        end else begin
          wb_d = ret_base;
          if (ws_q[ret_base]) begin
            ws_d      = ws_q & ~bit_at(wb_q);
            ret_valid = 1'b1;
            ret_pc    = {pc_val[31:30], a0_val[29:0]};
          end else begin
            owb_we    = 1'b1;
            owb_wdata = wb_q;
            excm_set  = 1'b1;
            epc_we    = 1'b1;
            epc_wdata = pc_val;
            exc_kind  = 4'd5 + {2'd0, ret_n};
          end
        end
      end
      OP_ROTW:   wb_d = wb_q + rot_ext[QW-1:0];
      OP_MOVSP:  if (ret_m == 2'd0) exc_kind = K_ALLOCA;
      OP_WBSET:  wb_d = base_wr;
      OP_OWBRST: wb_d = ps_owb;
      default: ;
    endcase
  end

  assign exc_valid = exc_kind != 4'd0;
  assign win_base  = wb_q;
  assign win_start = ws_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_q <= '0;
      ws_q <= NQ'(1);
    end else begin
      wb_q <= wb_d;
      ws_q <= ws_d;
    end
  end
endmodule

// File: rtl/win_call_ctrl_chk.sv
module win_call_ctrl_chk #(
  parameter int NAREG = 64,
  localparam int NQ = NAREG / 4,
  localparam int QW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [QW-1:0] win_base,
  input logic [NQ-1:0] win_start,
  input logic          rf_we,
  input logic          ret_valid,
  input logic          exc_valid,
  input logic [3:0]    exc_kind,
  input logic          owb_we,
  input logic [QW-1:0] owb_wdata,
  input logic          excm_set,
  input logic          epc_we
);
  assert_exc_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!rf_we && !ret_valid));

  assert_illegal_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind == 4'd1) |=> ($stable(win_base) && $stable(win_start)));

  assert_overflow_saves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind inside {4'd3, 4'd4, 4'd5}) |-> (owb_we && excm_set && epc_we && owb_wdata == win_base));

  assert_entry_marks_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && rf_we) |=> win_start[win_base]);

  assert_return_clears_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !win_start[$past(win_base)]);

  assert_underflow_saves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind inside {4'd6, 4'd7, 4'd8}) |=> $stable(win_start));

  assert_alloca_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind == 4'd2) |=> ($stable(win_base) && $stable(win_start)));
endmodule

bind win_call_ctrl win_call_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .win_base(win_base), .win_start(win_start),
  .rf_we(rf_we), .ret_valid(ret_valid), .exc_valid(exc_valid), .exc_kind(exc_kind),
  .owb_we(owb_we), .owb_wdata(owb_wdata), .excm_set(excm_set), .epc_we(epc_we)
);

// File: tb/sim_win_call_ctrl.sv
module sim_win_call_ctrl;
  localparam int NAREG = 64;
  localparam int NQ = NAREG / 4;
  localparam int QW = $clog2(NQ);
  localparam int OW = 1 + 4 + 32 + 1 + 32 + 1 + 4 + 1 + QW + 1 + 1 + 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] s_idx = '0, rot_amt = '0;
  logic [31:0] src_val = '0, imm_val = '0, a0_val = '0, pc_val = '0;
  logic [QW-1:0] base_wr = '0, ps_owb = '0;
  logic ps_woe = 1'b0, ps_excm = 1'b0;
  logic [1:0] ps_callinc = '0;
  logic [QW-1:0] win_base, owb_wdata;
  logic [NQ-1:0] win_start;
  logic rf_we, ret_valid, exc_valid, owb_we, excm_set, epc_we;
  logic [3:0] rf_idx, exc_kind;
  logic [31:0] rf_wdata, ret_pc, epc_wdata;

  always #4 clk = ~clk;

  win_call_ctrl #(.NAREG(NAREG)) u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .s_idx(s_idx), .src_val(src_val),
    .imm_val(imm_val), .a0_val(a0_val), .pc_val(pc_val), .rot_amt(rot_amt),
    .base_wr(base_wr), .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc),
    .ps_owb(ps_owb), .win_base(win_base), .win_start(win_start), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .exc_valid(exc_valid), .exc_kind(exc_kind), .owb_we(owb_we), .owb_wdata(owb_wdata),
    .excm_set(excm_set), .epc_we(epc_we), .epc_wdata(epc_wdata)
  );

  int n_cmp = 0, n_bad = 0;
  int mwb;
  logic [NQ-1:0] mws;
  bit finished = 1'b0;

  function automatic int wr(input int x);
    return ((x % NQ) + NQ) % NQ;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
    end
  endtask

  task automatic model(output logic [OW-1:0] e, output string tag);
    logic erf, eret, eowb, eexc, eepc;
    logic [3:0] eidx, ekind;
    logic [31:0] edat, epc, eepcd;
    logic [QW-1:0] eowbd;
    int first, nxt, k, n, m, r;
    int nwb;
    logic [NQ-1:0] nws;
    erf = 0; eret = 0; eowb = 0; eexc = 0; eepc = 0;
    eidx = 0; ekind = 0; edat = 0; epc = 0; eepcd = 0; eowbd = 0;
    nwb = mwb; nws = mws; tag = "R1";
    case (op)
      3'd1: begin
        if (s_idx > 3 || !ps_woe || ps_excm) begin
          ekind = 1; tag = "R3";
        end else begin
          first = 0;
          for (int d = 1; d <= NQ; d++) if (first == 0 && mws[wr(mwb + d)]) first = d;
          if (first != 0 && first <= int'(ps_callinc)) begin
            nxt = 0;
            for (int d = first + 1; d <= NQ; d++) if (nxt == 0 && mws[wr(mwb + d)]) nxt = d;
            k = (nxt == 0) ? 99 : nxt - first - 1;
            ekind = (k == 0) ? 4'd3 : (k == 1) ? 4'd4 : 4'd5;
            nwb = wr(mwb + first);
            eowb = 1; eowbd = QW'(mwb); eexc = 1; eepc = 1; eepcd = pc_val;
            tag = "R4 R5";
          end else begin
            erf = 1; eidx = {ps_callinc, s_idx[1:0]}; edat = src_val - imm_val;
            nwb = wr(mwb + int'(ps_callinc)); nws[nwb] = 1'b1; tag = "R6";
          end
        end
      end
      3'd2: begin
        n = int'(a0_val[31:30]);
        m = 0;
        for (int d = 3; d >= 1; d--) if (mws[wr(mwb - d)]) m = d;
        if (n == 0 || (m != 0 && m != n) || !ps_woe || ps_excm) begin
          ekind = 1; tag = "R7";
        end else begin
          nwb = wr(mwb - n);
          if (mws[nwb]) begin
            nws[mwb] = 1'b0; eret = 1; epc = {pc_val[31:30], a0_val[29:0]}; tag = "R8";
          end else begin
            ekind = 4'(5 + n); eowb = 1; eowbd = QW'(mwb); eexc = 1; eepc = 1; eepcd = pc_val;
            tag = "R9";
          end
        end
      end
      3'd3: begin
        r = rot_amt[3] ? int'(rot_amt) - 16 : int'(rot_amt);
        nwb = wr(mwb + r); tag = "R2";
      end
      3'd4: begin
        if (!mws[wr(mwb - 1)] && !mws[wr(mwb - 2)] && !mws[wr(mwb - 3)]) ekind = 2;
        tag = "R10";
      end
      3'd5: begin nwb = int'(base_wr); tag = "R11"; end
      3'd6: begin nwb = int'(ps_owb); tag = "R11"; end
      default: ;
    endcase
    e = {erf, eidx, edat, eret, epc, ekind != 0, ekind, eowb, eowbd, eexc, eepc, eepcd};
    mwb = nwb; mws = nws;
  endtask

  task automatic step;
    logic [OW-1:0] e;
    string tag;
    #1;
    model(e, tag);
    check(tag, {rf_we, rf_idx, rf_wdata, ret_valid, ret_pc, exc_valid, exc_kind,
                owb_we, owb_wdata, excm_set, epc_we, epc_wdata}, e);
    @(negedge clk);
    check({tag, " state"}, OW'({win_base, win_start}), OW'({QW'(mwb), mws}));
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mwb = 0; mws = NQ'(1);
    @(negedge clk);
    // R1 reset state and idle outputs
    check("R1", OW'({win_base, win_start, rf_we, ret_valid, exc_valid, owb_we, epc_we}),
          OW'({QW'(0), NQ'(1), 5'b0}));
    ps_woe = 1; ps_excm = 0;
    // R6 call with increment 1
    op = 1; ps_callinc = 1; s_idx = 1; src_val = 100; imm_val = 16; step();
    // R2 rotate by -2 wraps below zero
    op = 3; rot_amt = 4'hE; step();
    // R4 R5 call whose increment reaches live frames -> overflow of size 4
    op = 1; ps_callinc = 3; s_idx = 2; pc_val = 32'h1234_5678; #1;
    check("R5", OW'(exc_kind), OW'(4'd3));
    step();
    // R11 restore saved base
    op = 6; ps_owb = QW'(5); step();
    // R3 out-of-range source index
    op = 1; s_idx = 4'd5; step();
    // R3 exception mode set
    op = 1; s_idx = 0; ps_excm = 1; step();
    ps_excm = 0;
    for (int i = 0; i < 4000; i++) begin
      op = 3'($urandom_range(1, 6));
      if ($urandom_range(0, 9) < 5) op = ($urandom_range(0, 1) != 0) ? 3'd1 : 3'd2;
      s_idx = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
      src_val = $urandom; imm_val = $urandom; a0_val = $urandom; pc_val = $urandom;
      rot_amt = 4'($urandom); base_wr = QW'($urandom); ps_owb = QW'($urandom);
      ps_callinc = 2'($urandom);
      ps_woe = ($urandom_range(0, 15) != 0);
      ps_excm = ($urandom_range(0, 15) == 0);
      step();
    end
    op = 0; step();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule